// File: doc/BRIEF.md
# Sampling ADC Parallel Interface Logic

This block is the digital control side of a 16-bit successive-approximation converter that has a parallel output. A host drives an active-low chip select and a combined read/convert strobe, where high means read and low means convert. A conversion starts on a falling edge of the OR of these two lines. The block then holds an active-low busy flag low for a fixed number of clock cycles. A cycle counter stands in for the analog conversion time. When busy rises, the captured sample is in the output register.

The three-state data bus is modelled as a data word, an enable flag and a bad-data flag. The bad-data flag marks any result whose conversion started before the acquisition window after the previous conversion (or after reset) had run out. A fault input stands for an internal power cycle. It clears all conversion state and keeps the bus disabled while it is high.

Top module: `adc_pif`

## Requirements
- R1: With `cs_n` low and the block idle (`busy_n` high), a falling edge of `rd_cvt` starts a conversion, and `busy_n` is low after the next clock edge. A falling edge of `rd_cvt` while `cs_n` is high starts nothing.
- R2: With `rd_cvt` low and the block idle, a falling edge of `cs_n` starts a conversion.
- R3: `busy_n` stays low for exactly CONV_CYC clock cycles. On the edge where it rises, the output register already holds the new result.
- R4: Falling edges of the convert condition that arrive while `busy_n` is low are ignored. They neither restart nor lengthen the conversion.
- R5: `bus_oe` is 1 only when `cs_n` is low, `rd_cvt` is high and `pwr_fault` is low. When `bus_oe` is 0, `bus_data` reads all zeros and `bus_bad` reads 0.
- R6: A read during a conversion returns the previous result, which holds steady. After `busy_n` rises, the read returns the new result.
- R7: If `cs_n` and `rd_cvt` are both low in the first idle cycle after `busy_n` rises, a new conversion starts without a further edge, and its result has `bus_bad` = 1.
- R8: A conversion that starts fewer than ACQ_CYC idle cycles after `busy_n` rose (or after reset) has `bus_bad` = 1 on its result. Otherwise `bus_bad` = 0.
- R9: The result word is the 16-bit two's complement sample exactly as captured at the start edge, with bit 15 as the most significant bit.
- R10: While `pwr_fault` is high, `busy_n` goes high after the next edge, no conversion starts, and the bus is disabled. Both result registers are cleared, so the first read after the fault returns zero.
- R11: After reset, `busy_n` is 1, `bus_oe` is 0 and the stored result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_cvt | input | 1 | Read (high) / convert (low) strobe |
| pwr_fault | input | 1 | Internal power-cycle indication; clears state |
| sample_in | input | 16 | Sample value captured at conversion start |
| busy_n | output | 1 | Low while a conversion is in progress |
| bus_data | output | 16 | Data bus word, zero when disabled |
| bus_oe | output | 1 | Data bus enable (0 = high impedance) |
| bus_bad | output | 1 | Result on the bus came from a conversion without full acquisition |

## Verification
Conversions are started once by a falling read/convert edge under a low chip select and once by a falling chip select under a low read/convert. These two patterns separate the two start paths from a start that only looks at one line. Strobe toggles during busy and a held-low pair of controls at completion separate the lock-out from the back-to-back restart. A start issued right after completion, compared with one issued after a long idle period, checks that the bad flag follows the acquisition window and not the start path. A fault pulse in mid-conversion, followed by a read, shows that both the timer and the stored results are cleared.

// File: rtl/adc_pif_pkg.sv
package adc_pif_pkg;

    localparam int unsigned SMP_W    = 16;
    localparam int unsigned CONV_DEF = 20;
    localparam int unsigned ACQ_DEF  = 6;

    typedef logic [SMP_W-1:0] smp_t;

    typedef struct packed {
        logic bad;
        smp_t word;
    } result_t;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_CONV = 1'b1
    } phase_e;

    // Convert request is the OR of the two active-low controls.
    function automatic logic conv_level(input logic cs_n, input logic rd_cvt);
        return cs_n | rd_cvt;
    endfunction

endpackage

// File: rtl/adc_pif_trig.sv
module adc_pif_trig
    import adc_pif_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic rd_cvt,
    input  logic fault,
    input  logic idle,
    input  logic just_done,
    output logic start
);
    logic lvl;
    logic lvl_q;

    assign lvl = conv_level(cs_n, rd_cvt);

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl;
    end

    // Falling edge of the combined level, or a level already low at busy rise.
    assign start = idle & ~fault & ~lvl & (lvl_q | just_done);
endmodule

// File: rtl/adc_pif_timer.sv
module adc_pif_timer
    import adc_pif_pkg::*;
#(
    parameter int unsigned CONV_CYC = CONV_DEF,
    parameter int unsigned ACQ_CYC  = ACQ_DEF
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   fault,
    input  logic   start,
    output phase_e phase,
    output logic   complete,
    output logic   just_done,
    output logic   acq_ok
);
    localparam int unsigned CNT_W = $clog2(CONV_CYC + 1);
    localparam int unsigned ACQ_W = $clog2(ACQ_CYC + 1);

    logic [CNT_W-1:0] cnt;
    logic [ACQ_W-1:0] acq;

    assign complete = (phase == PH_CONV) && (cnt == CNT_W'(CONV_CYC - 1));
    assign acq_ok   = (acq == ACQ_W'(ACQ_CYC));

    always_ff @(posedge clk) begin
        if (rst || fault) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            acq       <= '0;
            just_done <= 1'b0;
        end else begin
            just_done <= complete;
            if (start) begin
                phase <= PH_CONV;
                cnt   <= '0;
                acq   <= '0;
            end else if (phase == PH_CONV) begin
                if (complete) begin
                    phase <= PH_IDLE;
                    acq   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (!acq_ok) begin
                acq <= acq + 1'b1;
            end
        end
    end
endmodule

// File: rtl/adc_pif_store.sv
module adc_pif_store
    import adc_pif_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    fault,
    input  logic    start,
    input  logic    complete,
    input  logic    acq_ok,
    input  smp_t    sample_in,
    input  logic    oe,
    output result_t bus_word
);
    result_t inflight;
    result_t held;

    always_ff @(posedge clk) begin
        if (rst || fault) begin
            inflight <= '0;
            held     <= '0;
        end else begin
            if (start) begin
                inflight.word <= sample_in;
                inflight.bad  <= ~acq_ok;
            end
            if (complete) held <= inflight;
        end
    end

    assign bus_word = oe ? held : '0;
endmodule

// File: rtl/adc_pif.sv
module adc_pif
    import adc_pif_pkg::*;
#(
    parameter int unsigned CONV_CYC = CONV_DEF,
    parameter int unsigned ACQ_CYC  = ACQ_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             rd_cvt,
    input  logic             pwr_fault,
    input  logic [SMP_W-1:0] sample_in,
    output logic             busy_n,
    output logic [SMP_W-1:0] bus_data,
    output logic             bus_oe,
    output logic             bus_bad
);
    phase_e  phase;
    logic    start, complete, just_done, acq_ok;
    result_t word;

    adc_pif_trig u_trig (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_cvt(rd_cvt), .fault(pwr_fault),
        .idle(phase == PH_IDLE), .just_done(just_done), .start(start)
    );

    adc_pif_timer #(.CONV_CYC(CONV_CYC), .ACQ_CYC(ACQ_CYC)) u_timer (
        .clk(clk), .rst(rst), .fault(pwr_fault), .start(start),
        .phase(phase), .complete(complete), .just_done(just_done), .acq_ok(acq_ok)
    );

    assign bus_oe = ~pwr_fault & ~cs_n & rd_cvt;

    adc_pif_store u_store (
        .clk(clk), .rst(rst), .fault(pwr_fault), .start(start),
        .complete(complete), .acq_ok(acq_ok), .sample_in(sample_in),
        .oe(bus_oe), .bus_word(word)
    );

    assign busy_n   = (phase != PH_CONV);
    assign bus_data = word.word;
    assign bus_bad  = word.bad;
endmodule

// File: rtl/adc_pif_chk.sv
module adc_pif_chk
    import adc_pif_pkg::*;
#(
    parameter int unsigned CONV_CYC = CONV_DEF
) (
    input logic             clk,
    input logic             rst,
    input logic             cs_n,
    input logic             pwr_fault,
    input logic             busy_n,
    input logic [SMP_W-1:0] bus_data,
    input logic             bus_oe,
    input logic             bus_bad
);
    localparam int unsigned LW = $clog2(CONV_CYC + 2);
    logic [LW-1:0] low_len;

    always_ff @(posedge clk) begin
        if (rst || busy_n) low_len <= '0;
        else               low_len <= low_len + 1'b1;
    end

    p_busy_bound_r3: assert property (@(posedge clk) disable iff (rst)
        !busy_n |-> low_len < LW'(CONV_CYC));

    p_busy_exact_r3: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy_n) && !$past(pwr_fault)) |-> low_len == LW'(CONV_CYC));

    p_cs_off_r5: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !bus_oe);

    p_quiet_bus_r5: assert property (@(posedge clk) disable iff (rst)
        !bus_oe |-> (bus_data == '0 && !bus_bad));

    p_hold_prev_r6: assert property (@(posedge clk) disable iff (rst)
        (!busy_n && !$past(busy_n) && bus_oe && $past(bus_oe)) |-> $stable(bus_data));

    p_fault_idle_r10: assert property (@(posedge clk) disable iff (rst)
        pwr_fault |=> busy_n);
endmodule

bind adc_pif adc_pif_chk #(.CONV_CYC(CONV_CYC)) u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .pwr_fault(pwr_fault), .busy_n(busy_n),
    .bus_data(bus_data), .bus_oe(bus_oe), .bus_bad(bus_bad)
);

// File: tb/adc_pif_tb.sv
module adc_pif_tb;
    import adc_pif_pkg::*;

    localparam int CONV = CONV_DEF;
    localparam int ACQ  = ACQ_DEF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, rd_cvt = 1'b1, pwr_fault = 1'b0;
    logic [15:0] sample_in = '0;
    logic busy_n, bus_oe, bus_bad;
    logic [15:0] bus_data;

    int n_chk = 0, n_fail = 0, cyc = 0;

    always #5 clk = ~clk;

    adc_pif u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_cvt(rd_cvt), .pwr_fault(pwr_fault),
        .sample_in(sample_in), .busy_n(busy_n), .bus_data(bus_data),
        .bus_oe(bus_oe), .bus_bad(bus_bad)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: remaining-cycle countdown and acquisition tally.
    bit          m_busy, m_bad, m_pend_bad, m_prev_lvl, m_fresh;
    int          m_left, m_acq;
    logic [15:0] m_res, m_pend;

    always @(posedge clk) begin
        bit lvl, fresh_next;
        lvl = cs_n | rd_cvt;
        fresh_next = 0;
        if (rst) begin
            m_busy = 0; m_left = 0; m_acq = 0; m_res = 0; m_bad = 0;
            m_pend = 0; m_pend_bad = 0; lvl = 0;
        end else if (pwr_fault) begin
            m_busy = 0; m_left = 0; m_acq = 0; m_res = 0; m_bad = 0;
            m_pend = 0; m_pend_bad = 0;
        end else if (m_busy) begin
            if (m_left == 1) begin
                m_busy = 0; m_res = m_pend; m_bad = m_pend_bad;
                m_acq = 0; fresh_next = 1;
            end else m_left--;
        end else if (!lvl && (m_prev_lvl || m_fresh)) begin
            m_busy = 1; m_left = CONV; m_pend = sample_in;
            m_pend_bad = (m_acq < ACQ); m_acq = 0;
        end else if (m_acq < ACQ) m_acq++;
        m_fresh = fresh_next;
        m_prev_lvl = lvl;
    end

    always @(posedge clk) begin
        bit oe;
        #3;
        if (!rst) begin
            oe = !pwr_fault && !cs_n && rd_cvt;
            chk("R3 busy_n vs model", busy_n, !m_busy);
            chk("R5 bus_oe vs model", bus_oe, oe);
            chk("R6 bus_data vs model", bus_data, oe ? m_res : 16'h0);
            chk("R8 bus_bad vs model", bus_bad, oe ? m_bad : 1'b0);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle();
        while (busy_n === 1'b0) @(negedge clk);
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL R3 watchdog actual %0d expected <= 20000 cycles", cyc);
            finish_up();
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        chk("R11 reset busy_n", busy_n, 1'b1);
        chk("R11 reset bus_oe", bus_oe, 1'b0);
        step(10);

        // R1: read/convert falls under low chip select
        cs_n = 1'b0; sample_in = 16'h1234;
        step(1);
        chk("R11 reset result zero", bus_data, 16'h0);
        chk("R5 enabled when cs low and rd high", bus_oe, 1'b1);
        rd_cvt = 1'b0;
        step(2);
        chk("R1 start from rd_cvt edge", busy_n, 1'b0);
        chk("R5 disabled while rd_cvt low", bus_oe, 1'b0);
        rd_cvt = 1'b1;
        step(1);
        chk("R6 read during conversion gives previous", bus_data, 16'h0);
        // R4: edges while busy are ignored
        for (int i = 0; i < 3; i++) begin
            rd_cvt = 1'b0; step(1); rd_cvt = 1'b1; step(1);
        end
        wait_idle();
        step(1);
        chk("R6 new result after busy rises", bus_data, 16'h1234);
        chk("R8 full acquisition not flagged", bus_bad, 1'b0);
        chk("R4 no restart from ignored edges", busy_n, 1'b1);

        // R1 negative: rd_cvt falls with cs high
        cs_n = 1'b1; step(1);
        chk("R5 disabled with cs high", bus_oe, 1'b0);
        rd_cvt = 1'b0; step(3);
        chk("R1 no start with cs high", busy_n, 1'b1);
        step(10);

        // R2: chip select falls under low read/convert, then back-to-back (R7)
        sample_in = 16'h8001;
        cs_n = 1'b0;
        step(2);
        chk("R2 start from cs_n edge", busy_n, 1'b0);
        sample_in = 16'h7FFE;
        step(28);
        chk("R7 restart without edge", busy_n, 1'b0);
        rd_cvt = 1'b1;
        step(2);
        chk("R9 negative result passes unchanged", bus_data, 16'h8001);
        chk("R8 first result not flagged", bus_bad, 1'b0);
        step(15);
        chk("R7 back-to-back result word", bus_data, 16'h7FFE);
        chk("R7 back-to-back result flagged", bus_bad, 1'b1);

        // R8: start right after completion, inside acquisition window
        sample_in = 16'h00FF;
        rd_cvt = 1'b0; step(1); rd_cvt = 1'b1;
        wait_idle();
        rd_cvt = 1'b0; sample_in = 16'h0F0F; step(1); rd_cvt = 1'b1;
        step(1);
        wait_idle();
        step(1);
        chk("R8 early start word", bus_data, 16'h0F0F);
        chk("R8 early start flagged", bus_bad, 1'b1);
        step(10);

        // R10: fault in mid-conversion
        rd_cvt = 1'b0; step(1); rd_cvt = 1'b1;
        step(5);
        pwr_fault = 1'b1;
        step(1);
        chk("R10 fault ends busy", busy_n, 1'b1);
        chk("R10 fault disables bus", bus_oe, 1'b0);
        rd_cvt = 1'b0; step(2);
        chk("R10 no start under fault", busy_n, 1'b1);
        rd_cvt = 1'b1; step(1);
        pwr_fault = 1'b0;
        step(1);
        chk("R10 results cleared", bus_data, 16'h0);
        chk("R10 bus back on", bus_oe, 1'b1);
        step(5);
        finish_up();
    end
endmodule